// File: doc/BRIEF.md
# Standby Clock-Gating Wake Controller

This block governs the deepest clock-gated sleep of a single processor subsystem. When software has set the low-power mode field to the standby code and then pulses an idle request, the controller switches off the processor clock enable and the enable for peripheral clocks derived from the system clock. The watchdog clock enable stays on throughout. The rest of the chip keeps running.

While asleep, the controller watches its wake sources. Three of them wake the subsystem directly: an inter-processor interrupt on flag 0, an NMI sent from the partner processor, and a watchdog interrupt that is enabled by a mask input. The fourth source is a bank of general-purpose inputs, chosen by a select mask. A selected input must be held low for a programmable number of oscillator cycles before it counts as a wake. Every wake path ends in the same sequence. The controller waits through a fixed clock restart delay, turns the clocks back on, and issues a one-cycle wake interrupt for the interrupt controller.

A software reset request for the subsystem is passed on only while the subsystem is awake. Hard resets act asynchronously in every state.

The controller has four states:

- ACTIVE: clocks are on.
- STANDBY: clocks are gated and the wake sources are watched.
- QUALIFY: a selected input is being held low and its cycles are counted.
- WAKE: the clock restart delay runs, and the interrupt is issued in the last cycle.

The transitions are:

- ACTIVE to STANDBY on an idle request with the standby code.
- STANDBY to WAKE on a direct source.
- STANDBY to QUALIFY when a selected input is low.
- QUALIFY to WAKE on a direct source or when the count completes.
- QUALIFY to STANDBY when the selected inputs go high.
- WAKE to ACTIVE after the interrupt cycle.

Top module: `standby_wake_ctrl`

## Requirements
- R1: After a hard reset, the controller is in ACTIVE. `cpu_clk_en` and `periph_clk_en` are 1, and `wake_int` is 0.
- R2: In ACTIVE, an edge that samples `idle_req`=1 with `lpm_sel`=2'b01 moves the controller to STANDBY. Both `cpu_clk_en` and `periph_clk_en` are 0 from that edge on. Any other `lpm_sel` value (2'b00, 2'b10, 2'b11) leaves the clocks on.
- R3: `wd_clk_en` is 1 in every state, including STANDBY, QUALIFY and WAKE.
- R4: In STANDBY or QUALIFY, an edge that samples `ipc_flag0_int`, `nmi_remote`, or `wd_int` with `wd_wake_en`=1 moves the controller to WAKE. A one-cycle pulse is enough. `wd_int` with `wd_wake_en`=0 is ignored.
- R5: The clock restart delay is 2 cycles. If a wake is sampled at edge E0, the clocks stay off until the edge E0+2 turns them on. `wake_int` is 1 in that same cycle.
- R6: Bit i of `gpio_wake_sel` enables `gpio_n[i]`. Only an enabled input driven low starts qualification. A low level on an input that is not enabled leaves the clocks off.
- R7: An enabled input that is low on `qual_len`+2 consecutive edges completes qualification. The first of those edges moves STANDBY to QUALIFY. `wake_int` then follows 2 cycles after the last edge, so it is seen `qual_len`+4 cycles after the input falls. A `qual_len` of 0 is valid.
- R8: If QUALIFY samples no enabled input low, the controller returns to STANDBY and the count restarts from zero.
- R9: `wake_int` lasts exactly one cycle. The controller is in ACTIVE the next cycle, with the clocks still on.
- R10: `cpu_sw_rst` follows `sw_reset_req` in ACTIVE only. In any sleep state, the request is blocked and does not wake the subsystem.
- R11: Asserting `rst_n` low forces ACTIVE asynchronously. The clocks turn on without waiting for a clock edge.
- R12: A direct source sampled during QUALIFY ends qualification at once and takes the same 2-cycle restart path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Combined hard reset, active low, asynchronous |
| lpm_sel | input | 2 | Low-power mode field; 2'b01 selects standby |
| idle_req | input | 1 | Idle request pulse from the processor |
| ipc_flag0_int | input | 1 | Inter-processor interrupt, flag 0 |
| nmi_remote | input | 1 | NMI issued from the partner processor |
| wd_int | input | 1 | Watchdog interrupt |
| wd_wake_en | input | 1 | Lets the watchdog interrupt wake the subsystem |
| gpio_n | input | 64 | General-purpose inputs, low is active |
| gpio_wake_sel | input | 64 | Enables each input as a wake source |
| qual_len | input | 8 | Qualification length in oscillator cycles |
| sw_reset_req | input | 1 | Software reset request for this subsystem |
| cpu_clk_en | output | 1 | Processor clock enable |
| periph_clk_en | output | 1 | Derived peripheral clock enable |
| wd_clk_en | output | 1 | Watchdog clock enable |
| wake_int | output | 1 | One-cycle wake interrupt |
| cpu_sw_rst | output | 1 | Forwarded software reset |

## Verification
All outputs are decoded combinationally from the state register and its counters, so each one changes right after the edge that moves the state.

The bench drives its stimulus on the falling edge and samples on a later falling edge:
- Gating appears one falling edge after the idle request.
- A direct wake shows `wake_int` three falling edges after the source is driven.
- A GPIO wake shows it `qual_len`+4 falling edges after the input falls.

Every falling edge before the expected one is checked to show the clocks still off. The interrupt is then checked to be gone on the following falling edge.

The asynchronous reset and the forwarded software reset are checked one time step after the input changes, within the same cycle.

// File: rtl/stbw_pkg.sv
package stbw_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'd0,
        ST_STANDBY = 2'd1,
        ST_QUALIFY = 2'd2,
        ST_WAKE    = 2'd3
    } stbw_state_e;

    localparam logic [1:0] LPM_CODE_STANDBY = 2'b01;

endpackage

// File: rtl/stbw_src_merge.sv
module stbw_src_merge #(
    parameter int GPIO_W = 64
) (
    input  logic              ipc_flag0_int,
    input  logic              nmi_remote,
    input  logic              wd_int,
    input  logic              wd_wake_en,
    input  logic [GPIO_W-1:0] gpio_n,
    input  logic [GPIO_W-1:0] gpio_wake_sel,
    output logic              direct_wake,
    output logic              gpio_low
);
    logic [GPIO_W-1:0] pin_hit;

    // Per-pin qualifier: an enabled input that is driven low
    for (genvar g = 0; g < GPIO_W; g++) begin : g_pin
        assign pin_hit[g] = gpio_wake_sel[g] & ~gpio_n[g];
    end

    assign gpio_low    = |pin_hit;
    assign direct_wake = ipc_flag0_int | nmi_remote | (wd_int & wd_wake_en);
endmodule

// File: rtl/stbw_qual_cnt.sv
module stbw_qual_cnt #(
    parameter int QUAL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              low,
    input  logic [QUAL_W-1:0] qual_len,
    output logic              done
);
    logic [QUAL_W-1:0] cnt_q;

    // Counts consecutive low samples while qualifying; any gap clears it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || !low) begin
            cnt_q <= '0;
        end else if (cnt_q != qual_len) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && low && (cnt_q == qual_len);
endmodule

// File: rtl/stbw_restart_cnt.sv
module stbw_restart_cnt #(
    parameter int RESTART_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int DW = $clog2(RESTART_CYC + 1);
    localparam logic [DW-1:0] LAST = DW'(RESTART_CYC);

    logic [DW-1:0] dly_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q <= '0;
        end else if (!run) begin
            dly_q <= '0;
        end else if (dly_q != LAST) begin
            dly_q <= dly_q + 1'b1;
        end
    end

    assign done = run && (dly_q == LAST);
endmodule

// File: rtl/standby_wake_ctrl.sv
module standby_wake_ctrl
    import stbw_pkg::*;
#(
    parameter int GPIO_W      = 64,
    parameter int QUAL_W      = 8,
    parameter int RESTART_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        lpm_sel,
    input  logic              idle_req,
    input  logic              ipc_flag0_int,
    input  logic              nmi_remote,
    input  logic              wd_int,
    input  logic              wd_wake_en,
    input  logic [GPIO_W-1:0] gpio_n,
    input  logic [GPIO_W-1:0] gpio_wake_sel,
    input  logic [QUAL_W-1:0] qual_len,
    input  logic              sw_reset_req,
    output logic              cpu_clk_en,
    output logic              periph_clk_en,
    output logic              wd_clk_en,
    output logic              wake_int,
    output logic              cpu_sw_rst
);
    stbw_state_e state, state_nxt;
    logic direct_wake, gpio_low, qual_done, restart_done;

    stbw_src_merge #(.GPIO_W(GPIO_W)) u_merge (
        .ipc_flag0_int (ipc_flag0_int),
        .nmi_remote    (nmi_remote),
        .wd_int        (wd_int),
        .wd_wake_en    (wd_wake_en),
        .gpio_n        (gpio_n),
        .gpio_wake_sel (gpio_wake_sel),
        .direct_wake   (direct_wake),
        .gpio_low      (gpio_low)
    );

    stbw_qual_cnt #(.QUAL_W(QUAL_W)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state == ST_QUALIFY),
        .low      (gpio_low),
        .qual_len (qual_len),
        .done     (qual_done)
    );

    stbw_restart_cnt #(.RESTART_CYC(RESTART_CYC)) u_restart (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_WAKE),
        .done  (restart_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_ACTIVE;
        else        state <= state_nxt;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_ACTIVE: begin
                if (idle_req && lpm_sel == LPM_CODE_STANDBY) state_nxt = ST_STANDBY;
            end
            ST_STANDBY: begin
                if (direct_wake)   state_nxt = ST_WAKE;
                else if (gpio_low) state_nxt = ST_QUALIFY;
            end
            ST_QUALIFY: begin
                if (direct_wake)    state_nxt = ST_WAKE;
                else if (!gpio_low) state_nxt = ST_STANDBY;
                else if (qual_done) state_nxt = ST_WAKE;
            end
            ST_WAKE: begin
                if (restart_done) state_nxt = ST_ACTIVE;
            end
            default: state_nxt = ST_ACTIVE;
        endcase
    end

    // Output decode
    always_comb begin
        cpu_clk_en    = 1'b0;
        periph_clk_en = 1'b0;
        wake_int      = 1'b0;
        cpu_sw_rst    = 1'b0;
        unique case (state)
            ST_ACTIVE: begin
                cpu_clk_en    = 1'b1;
                periph_clk_en = 1'b1;
                cpu_sw_rst    = sw_reset_req;
            end
            ST_STANDBY, ST_QUALIFY: ;
            ST_WAKE: begin
                cpu_clk_en    = restart_done;
                periph_clk_en = restart_done;
                wake_int      = restart_done;
            end
            default: ;
        endcase
    end

    assign wd_clk_en = 1'b1;
endmodule

// File: rtl/stbw_checker.sv
module stbw_checker
    import stbw_pkg::*;
#(
    parameter int GPIO_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input stbw_state_e       state,
    input logic [1:0]        lpm_sel,
    input logic              idle_req,
    input logic              ipc_flag0_int,
    input logic              nmi_remote,
    input logic              wd_int,
    input logic              wd_wake_en,
    input logic [GPIO_W-1:0] gpio_n,
    input logic [GPIO_W-1:0] gpio_wake_sel,
    input logic              cpu_clk_en,
    input logic              periph_clk_en,
    input logic              wake_int,
    input logic              cpu_sw_rst
);
    logic src_any, sel_low, seen_edge;

    assign src_any = ipc_flag0_int | nmi_remote | (wd_int & wd_wake_en);
    assign sel_low = |(gpio_wake_sel & ~gpio_n);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_edge <= 1'b0;
        else        seen_edge <= 1'b1;
    end

    p_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && idle_req && lpm_sel == LPM_CODE_STANDBY)
        |=> (state == ST_STANDBY && !cpu_clk_en && !periph_clk_en));

    p_clkpair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en == periph_clk_en);

    p_direct_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_STANDBY || state == ST_QUALIFY) && src_any)
        |=> (state == ST_WAKE && !wake_int));

    p_clkrise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_edge && $rose(cpu_clk_en)) |-> wake_int);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STANDBY && !src_any && !sel_low) |=> state == ST_STANDBY);

    p_requal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_QUALIFY && !src_any && !sel_low) |=> state == ST_STANDBY);

    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_int |=> (!wake_int && state == ST_ACTIVE && cpu_clk_en));

    p_swrst_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_clk_en |-> !cpu_sw_rst);
endmodule

bind standby_wake_ctrl stbw_checker #(.GPIO_W(GPIO_W)) u_stbw_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .state         (state),
    .lpm_sel       (lpm_sel),
    .idle_req      (idle_req),
    .ipc_flag0_int (ipc_flag0_int),
    .nmi_remote    (nmi_remote),
    .wd_int        (wd_int),
    .wd_wake_en    (wd_wake_en),
    .gpio_n        (gpio_n),
    .gpio_wake_sel (gpio_wake_sel),
    .cpu_clk_en    (cpu_clk_en),
    .periph_clk_en (periph_clk_en),
    .wake_int      (wake_int),
    .cpu_sw_rst    (cpu_sw_rst)
);

// File: tb/standby_wake_ctrl_tb_top.sv
`timescale 1ns/1ps
module standby_wake_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  lpm_sel = 2'b00;
    logic        idle_req = 1'b0;
    logic        ipc_flag0_int = 1'b0;
    logic        nmi_remote = 1'b0;
    logic        wd_int = 1'b0;
    logic        wd_wake_en = 1'b0;
    logic [63:0] gpio_n = '1;
    logic [63:0] gpio_wake_sel = '0;
    logic [7:0]  qual_len = 8'd0;
    logic        sw_reset_req = 1'b0;
    logic        cpu_clk_en, periph_clk_en, wd_clk_en, wake_int, cpu_sw_rst;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    standby_wake_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .lpm_sel(lpm_sel), .idle_req(idle_req),
        .ipc_flag0_int(ipc_flag0_int), .nmi_remote(nmi_remote), .wd_int(wd_int),
        .wd_wake_en(wd_wake_en), .gpio_n(gpio_n), .gpio_wake_sel(gpio_wake_sel),
        .qual_len(qual_len), .sw_reset_req(sw_reset_req),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .wd_clk_en(wd_clk_en),
        .wake_int(wake_int), .cpu_sw_rst(cpu_sw_rst)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic enter_standby();
        @(negedge clk);
        lpm_sel = 2'b01; idle_req = 1'b1;
        @(negedge clk);
        lpm_sel = 2'b00; idle_req = 1'b0;
        chk("R2 cpu gated", cpu_clk_en, 0);
        chk("R2 periph gated", periph_clk_en, 0);
        chk("R3 wd clk", wd_clk_en, 1);
    endtask

    // Clocks off for n-1 falling edges, wake pulse on edge n, then gone
    task automatic expect_wake(input string req, input int n);
        for (int k = 1; k < n; k++) begin
            @(negedge clk);
            chk({req, " clk still off"}, cpu_clk_en, 0);
            chk({req, " no early wake"}, wake_int, 0);
            chk("R3 wd clk in sleep", wd_clk_en, 1);
        end
        @(negedge clk);
        chk({req, " R5 clk restored"}, cpu_clk_en, 1);
        chk({req, " R5 periph restored"}, periph_clk_en, 1);
        chk({req, " wake_int"}, wake_int, 1);
        @(negedge clk);
        chk("R9 pulse ends", wake_int, 0);
        chk("R9 clk stays on", cpu_clk_en, 1);
    endtask

    task automatic t_reset();
        chk("R1 cpu clk", cpu_clk_en, 1);
        chk("R1 periph clk", periph_clk_en, 1);
        chk("R1 wake_int", wake_int, 0);
        chk("R3 wd clk", wd_clk_en, 1);
    endtask

    task automatic t_no_entry();
        for (int m = 0; m < 4; m++) begin
            if (m == 1) continue;
            @(negedge clk);
            lpm_sel = 2'(m); idle_req = 1'b1;
            @(negedge clk);
            idle_req = 1'b0;
            chk("R2 other mode keeps clk", cpu_clk_en, 1);
        end
        lpm_sel = 2'b00;
    endtask

    task automatic t_direct(input int which);
        enter_standby();
        if (which == 0) ipc_flag0_int = 1'b1;
        else if (which == 1) nmi_remote = 1'b1;
        else begin wd_wake_en = 1'b1; wd_int = 1'b1; end
        @(negedge clk);
        ipc_flag0_int = 1'b0; nmi_remote = 1'b0; wd_int = 1'b0;
        chk("R4 in restart", cpu_clk_en, 0);
        chk("R5 no wake yet", wake_int, 0);
        expect_wake("R4", 2);
        wd_wake_en = 1'b0;
    endtask

    task automatic t_wd_masked();
        enter_standby();
        wd_wake_en = 1'b0; wd_int = 1'b1;
        repeat (6) @(negedge clk);
        chk("R4 masked wd ignored", cpu_clk_en, 0);
        chk("R4 masked wd no int", wake_int, 0);
        wd_int = 1'b0;
        ipc_flag0_int = 1'b1;
        @(negedge clk);
        ipc_flag0_int = 1'b0;
        expect_wake("R4", 2);
    endtask

    task automatic t_gpio(input int bitn, input int q);
        gpio_wake_sel = 64'd1 << bitn;
        qual_len = 8'(q);
        enter_standby();
        gpio_n[bitn] = 1'b0;
        expect_wake("R7", q + 4);
        gpio_n = '1;
    endtask

    task automatic t_gpio_unselected();
        gpio_wake_sel = 64'd1 << 5;
        qual_len = 8'd0;
        enter_standby();
        gpio_n[6] = 1'b0;
        repeat (10) @(negedge clk);
        chk("R6 unselected pin ignored", cpu_clk_en, 0);
        gpio_n = '1;
        nmi_remote = 1'b1;
        @(negedge clk);
        nmi_remote = 1'b0;
        expect_wake("R4", 2);
    endtask

    task automatic t_gpio_glitch();
        gpio_wake_sel = 64'd1 << 17;
        qual_len = 8'd3;
        enter_standby();
        gpio_n[17] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        gpio_n[17] = 1'b1;
        @(negedge clk);
        chk("R8 back to standby", cpu_clk_en, 0);
        gpio_n[17] = 1'b0;
        expect_wake("R8 restarted count", 7);
        gpio_n = '1;
    endtask

    task automatic t_preempt();
        gpio_wake_sel = 64'd1 << 40;
        qual_len = 8'd200;
        enter_standby();
        gpio_n[40] = 1'b0;
        repeat (3) @(negedge clk);
        ipc_flag0_int = 1'b1;
        @(negedge clk);
        ipc_flag0_int = 1'b0;
        chk("R12 still gated", cpu_clk_en, 0);
        expect_wake("R12", 2);
        gpio_n = '1;
    endtask

    task automatic t_swreset();
        @(negedge clk);
        sw_reset_req = 1'b1;
        #1;
        chk("R10 forwarded when active", cpu_sw_rst, 1);
        sw_reset_req = 1'b0;
        enter_standby();
        sw_reset_req = 1'b1;
        #1;
        chk("R10 blocked in standby", cpu_sw_rst, 0);
        repeat (5) @(negedge clk);
        chk("R10 no wake", cpu_clk_en, 0);
        chk("R10 still blocked", cpu_sw_rst, 0);
        sw_reset_req = 1'b0;
        ipc_flag0_int = 1'b1;
        @(negedge clk);
        ipc_flag0_int = 1'b0;
        expect_wake("R4", 2);
    endtask

    task automatic t_hard_reset();
        enter_standby();
        #1 rst_n = 1'b0;
        #1;
        chk("R11 async clk on", cpu_clk_en, 1);
        chk("R11 async periph on", periph_clk_en, 1);
        chk("R11 no wake int", wake_int, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 stays active", cpu_clk_en, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_entry();
        t_direct(0);
        t_direct(1);
        t_direct(2);
        t_wd_masked();
        t_gpio(5, 3);
        t_gpio(63, 0);
        t_gpio(0, 20);
        t_gpio_unselected();
        t_gpio_glitch();
        t_preempt();
        t_swreset();
        t_hard_reset();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule